// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a successive-approximation analog-to-digital converter. A start request picks one analog channel. The sequencer reads that channel's 3-bit sample-time code from a small per-channel configuration bank and raises the sample/hold control for the matching number of clock cycles. It then holds the sampler and runs a binary search, one bit per clock and most significant bit first. On each cycle it presents a trial code to an external DAC and reads back an external comparator.

When the last bit is decided, the 12-bit code and the channel it belongs to are published, and a single-cycle end-of-conversion pulse is raised. An abort input ends either phase at once. An aborted run leaves no result and no pulse. The analog sampler, the DAC, the comparator and any scan or transfer logic sit outside this block.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy, sample/hold, end-of-conversion and the DAC code are 0, the result and result channel are 0, and every channel's sample-time code is 0.
- R2: The sample/hold output stays high for a number of cycles set by the selected 3-bit code: 0=3, 1=15, 2=28, 3=56, 4=84, 5=112, 6=144 and 7=480 cycles.
- R3: Each channel keeps its own code, written through cfg_we/cfg_chan/cfg_code. A conversion uses the code of the channel it was started on.
- R4: Busy stays high for exactly the sample cycles plus 12 conversion cycles. Sample/hold is high only in the first part of that window and is low in idle.
- R5: The conversion phase sets trial bits from bit 11 down to bit 0, one per cycle, and the first trial code is 0x800. A bit is kept when cmp_in is 1 (input at or above the trial code) and cleared otherwise. The result is therefore the largest code not above the input.
- R6: The result and result channel update in the cycle after the last bit is decided. In that same cycle, end-of-conversion is high for exactly one cycle and busy is low.
- R7: Abort while busy, in either phase, returns the block to idle on the next cycle. No end-of-conversion pulse follows, and the result and result channel keep their earlier values.
- R8: A start request while busy is ignored. The running conversion keeps its channel and its length, and no second conversion follows.
- R9: The channel and its sample length are captured at start. A configuration write during a conversion affects only later conversions.
- R10: The DAC code output is 0 whenever the block is not in the conversion phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a channel's sample-time code |
| cfg_chan | input | CHAN_W | Channel addressed by the write |
| cfg_code | input | 3 | Sample-time code to store |
| start | input | 1 | Conversion request, taken only when idle |
| chan_sel | input | CHAN_W | Channel to convert |
| abort | input | 1 | Terminates a running conversion |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC code |
| dac_code | output | RES_BITS | Trial code for the DAC |
| sh_ctrl | output | 1 | Sample/hold control, high while sampling |
| busy | output | 1 | High during the sample and conversion phases |
| result | output | RES_BITS | Last completed conversion code |
| result_chan | output | CHAN_W | Channel of the last completed conversion |
| eoc | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The assertions check on every cycle that sample/hold implies busy, that end-of-conversion is a lone pulse that never overlaps busy, that an abort or a start while busy behaves as required, that the DAC code is zero outside conversion, and that the trial mask holds exactly one bit. Phase lengths for each code, the search outcome for various input levels, and the independence of channel codes can only be shown by the bench's scenarios. The same is true of the effect of configuration writes made during a run, because each of these depends on counting whole conversions.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   localparam int CODE_W = 3;
   localparam int SCNT_W = 9;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2
   } seq_state_t;

   // number of sample/hold cycles for each sample-time code
   function automatic logic [SCNT_W-1:0] smp_cycles(input logic [CODE_W-1:0] code);
      logic [SCNT_W-1:0] n;
      case (code)
         3'd0:    n = SCNT_W'(3);
         3'd1:    n = SCNT_W'(15);
         3'd2:    n = SCNT_W'(28);
         3'd3:    n = SCNT_W'(56);
         3'd4:    n = SCNT_W'(84);
         3'd5:    n = SCNT_W'(112);
         3'd6:    n = SCNT_W'(144);
         default: n = SCNT_W'(480);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/sar_seq_cfgbank.sv
module sar_seq_cfgbank
   import sar_seq_pkg::*;
#(
   parameter int NUM_CHAN = 8,
   parameter int CHAN_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHAN_W-1:0] wr_chan,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [CHAN_W-1:0] rd_chan,
   output logic [CODE_W-1:0] rd_code
);

   logic [CODE_W-1:0] code_q [NUM_CHAN];

   if (NUM_CHAN < 1) begin : g_bad_chan
      $error("sar_seq_cfgbank: NUM_CHAN must be at least 1");
   end
   if ((1 << CHAN_W) < NUM_CHAN) begin : g_bad_width
      $error("sar_seq_cfgbank: CHAN_W too narrow for NUM_CHAN");
   end

   for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_q[ch] <= '0;
         else if (wr_en && (wr_chan == CHAN_W'(ch)))
            code_q[ch] <= wr_code;
      end
   end

   always_comb begin
      rd_code = '0;
      for (int ch = 0; ch < NUM_CHAN; ch++)
         if (rd_chan == CHAN_W'(ch)) rd_code = code_q[ch];
   end

   // R3: a write lands only in the addressed channel's entry
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (32'(wr_chan) < NUM_CHAN) && (rd_chan == wr_chan))
         |=> (rd_code == $past(wr_code)) || $past(rd_chan) != rd_chan
         || (wr_en && wr_chan == rd_chan));

endmodule

// File: rtl/sar_seq_engine.sv
module sar_seq_engine #(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic                cmp_in,
   output logic [RES_BITS-1:0] trial,
   output logic                last,
   output logic [RES_BITS-1:0] final_code
);

   logic [RES_BITS-1:0] acc_q;
   logic [RES_BITS-1:0] mask_q;

   if (RES_BITS < 2) begin : g_bad_res
      $error("sar_seq_engine: RES_BITS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         mask_q <= '0;
      end else if (load) begin
         acc_q  <= '0;
         mask_q <= {1'b1, {(RES_BITS-1){1'b0}}};
      end else if (step) begin
         if (cmp_in) acc_q <= acc_q | mask_q;
         mask_q <= mask_q >> 1;
      end
   end

   assign trial      = step ? (acc_q | mask_q) : '0;
   assign last       = step & mask_q[0];
   assign final_code = cmp_in ? (acc_q | mask_q) : acc_q;

   // R5: exactly one trial bit is under test on every conversion cycle
   a_r5_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> ($countones(mask_q) == 1));

   // R5: search starts at the most significant bit
   a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> mask_q[RES_BITS-1]);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter int NUM_CHAN = 8,
   parameter int RES_BITS = 12,
   parameter int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CHAN_W-1:0]   cfg_chan,
   input  logic [CODE_W-1:0]   cfg_code,
   input  logic                start,
   input  logic [CHAN_W-1:0]   chan_sel,
   input  logic                abort,
   input  logic                cmp_in,
   output logic [RES_BITS-1:0] dac_code,
   output logic                sh_ctrl,
   output logic                busy,
   output logic [RES_BITS-1:0] result,
   output logic [CHAN_W-1:0]   result_chan,
   output logic                eoc
);

   seq_state_t          state_q;
   logic [SCNT_W-1:0]   scnt_q;
   logic [CHAN_W-1:0]   lat_chan_q;
   logic [RES_BITS-1:0] result_q;
   logic [CHAN_W-1:0]   rchan_q;
   logic                eoc_q;

   logic [CODE_W-1:0]   sel_code;
   logic                sar_load;
   logic                sar_step;
   logic                sar_last;
   logic [RES_BITS-1:0] sar_trial;
   logic [RES_BITS-1:0] sar_final;

   sar_seq_cfgbank #(
      .NUM_CHAN (NUM_CHAN),
      .CHAN_W   (CHAN_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_chan (cfg_chan),
      .wr_code (cfg_code),
      .rd_chan (chan_sel),
      .rd_code (sel_code)
   );

   assign sar_load = (state_q == ST_SAMPLE) && (scnt_q == '0) && !abort;
   assign sar_step = (state_q == ST_CONV);

   sar_seq_engine #(
      .RES_BITS (RES_BITS)
   ) u_sar (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (sar_load),
      .step       (sar_step),
      .cmp_in     (cmp_in),
      .trial      (sar_trial),
      .last       (sar_last),
      .final_code (sar_final)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         scnt_q     <= '0;
         lat_chan_q <= '0;
         result_q   <= '0;
         rchan_q    <= '0;
         eoc_q      <= 1'b0;
      end else begin
         eoc_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q    <= ST_SAMPLE;
                  scnt_q     <= smp_cycles(sel_code) - SCNT_W'(1);
                  lat_chan_q <= chan_sel;
               end
            end
            ST_SAMPLE: begin
               if (abort)               state_q <= ST_IDLE;
               else if (scnt_q == '0)   state_q <= ST_CONV;
               else                     scnt_q  <= scnt_q - SCNT_W'(1);
            end
            ST_CONV: begin
               if (abort) begin
                  state_q <= ST_IDLE;
               end else if (sar_last) begin
                  state_q  <= ST_IDLE;
                  result_q <= sar_final;
                  rchan_q  <= lat_chan_q;
                  eoc_q    <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dac_code    = sar_trial;
   assign sh_ctrl     = (state_q == ST_SAMPLE);
   assign busy        = (state_q != ST_IDLE);
   assign result      = result_q;
   assign result_chan = rchan_q;
   assign eoc         = eoc_q;

   // R4: sampling only happens inside a busy window
   a_r4_sh_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sh_ctrl |-> busy);

   // R6: end-of-conversion is a single-cycle pulse
   a_r6_eoc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);

   // R6: the block is idle while end-of-conversion is shown
   a_r6_eoc_idle: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> !busy);

   // R6: the result only moves together with end-of-conversion
   a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc |-> $stable(result) && $stable(result_chan));

   // R7: abort ends the run without a pulse
   a_r7_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort) |=> !busy && !eoc);

   // R8: a start while busy does not retarget the conversion
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(lat_chan_q));

   // R10: the DAC is parked at zero outside the conversion phase
   a_r10_dac_park: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy || sh_ctrl) |-> (dac_code == '0));

endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;

   localparam int NCH = 8;
   localparam int CW  = 3;
   localparam int RB  = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [CW-1:0] cfg_chan = '0;
   logic [2:0]    cfg_code = '0;
   logic          start = 1'b0;
   logic [CW-1:0] chan_sel = '0;
   logic          abort = 1'b0;
   logic          cmp_in;
   logic [RB-1:0] dac_code;
   logic          sh_ctrl;
   logic          busy;
   logic [RB-1:0] result;
   logic [CW-1:0] result_chan;
   logic          eoc;
   logic [RB-1:0] vin = '0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   // comparator model: high when the input is at or above the trial code
   assign cmp_in = (vin >= dac_code);

   sar_conv_seq #(.NUM_CHAN(NCH), .RES_BITS(RB)) u_sar_conv_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
      .cfg_code(cfg_code), .start(start), .chan_sel(chan_sel), .abort(abort),
      .cmp_in(cmp_in), .dac_code(dac_code), .sh_ctrl(sh_ctrl), .busy(busy),
      .result(result), .result_chan(result_chan), .eoc(eoc)
   );

   function automatic int exp_len(input int code);
      case (code)
         0: return 3;    1: return 15;   2: return 28;   3: return 56;
         4: return 84;   5: return 112;  6: return 144;  default: return 480;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input int ch, input int code);
      @(negedge clk);
      cfg_we = 1'b1; cfg_chan = CW'(ch); cfg_code = 3'(code);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // kind: 0 none, 1 start on channel alt, 2 write code alt to ch, 3 abort
   task automatic run_conv(input int ch, input int val, input int kind,
                           input int at, input int alt,
                           output int shc, output int bc, output int ec,
                           output int fdac);
      shc = 0; bc = 0; ec = 0; fdac = -1;
      @(negedge clk);
      vin = RB'(val); chan_sel = CW'(ch); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 2000; k++) begin
         start = 1'b0; cfg_we = 1'b0; abort = 1'b0;
         if (k == at) begin
            if (kind == 1) begin start = 1'b1; chan_sel = CW'(alt); end
            if (kind == 2) begin cfg_we = 1'b1; cfg_chan = CW'(ch); cfg_code = 3'(alt); end
            if (kind == 3) abort = 1'b1;
         end
         if (busy) bc++;
         if (sh_ctrl) shc++;
         if (busy && !sh_ctrl && fdac < 0) fdac = int'(dac_code);
         if (!busy && dac_code != '0)
            chk(1'b0, "R10 dac parked in idle", int'(dac_code), 0);
         if (eoc) begin ec++; break; end
         if (!busy) break;
         @(negedge clk);
      end
      start = 1'b0; cfg_we = 1'b0; abort = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (eoc) ec++;
         if (busy) bc++;
      end
   endtask

   task automatic t_reset;
      chk(busy == 1'b0,    "R1 busy at reset", int'(busy), 0);
      chk(sh_ctrl == 1'b0, "R1 sh_ctrl at reset", int'(sh_ctrl), 0);
      chk(eoc == 1'b0,     "R1 eoc at reset", int'(eoc), 0);
      chk(dac_code == '0,  "R1 dac at reset", int'(dac_code), 0);
      chk(result == '0,    "R1 result at reset", int'(result), 0);
      chk(result_chan == '0, "R1 result_chan at reset", int'(result_chan), 0);
   endtask

   task automatic t_code_sweep;
      int shc, bc, ec, fd;
      for (int c = 0; c < 8; c++) begin
         cfg_write(0, c);
         run_conv(0, 100 + c * 37, 0, -1, 0, shc, bc, ec, fd);
         chk(shc == exp_len(c), "R2 sample length per code", shc, exp_len(c));
         chk(bc == exp_len(c) + 12, "R4 busy = sample + 12", bc, exp_len(c) + 12);
         chk(ec == 1, "R6 single eoc", ec, 1);
         chk(int'(result) == 100 + c * 37, "R5 result", int'(result), 100 + c * 37);
      end
   endtask

   task automatic t_per_channel;
      int shc, bc, ec, fd;
      cfg_write(3, 0);
      cfg_write(5, 6);
      run_conv(5, 1234, 0, -1, 0, shc, bc, ec, fd);
      chk(shc == 144, "R3 channel 5 own code", shc, 144);
      chk(int'(result_chan) == 5, "R6 result_chan", int'(result_chan), 5);
      run_conv(3, 4000, 0, -1, 0, shc, bc, ec, fd);
      chk(shc == 3, "R3 channel 3 own code", shc, 3);
      chk(int'(result_chan) == 3, "R6 result_chan", int'(result_chan), 3);
   endtask

   task automatic t_sar_patterns;
      int shc, bc, ec, fd;
      int vals [6] = '{0, 4095, 2048, 2047, 2650, 1};
      cfg_write(1, 0);
      foreach (vals[i]) begin
         run_conv(1, vals[i], 0, -1, 0, shc, bc, ec, fd);
         chk(int'(result) == vals[i], "R5 search outcome", int'(result), vals[i]);
         chk(fd == 2048, "R5 first trial is MSB", fd, 2048);
      end
   endtask

   task automatic t_abort;
      int shc, bc, ec, fd;
      logic [RB-1:0] prev;
      prev = result;
      run_conv(0, 77, 3, 1, 0, shc, bc, ec, fd);   // channel 0 uses code 7
      chk(ec == 0, "R7 no eoc after sample abort", ec, 0);
      chk(bc == 2, "R7 idle after sample abort", bc, 2);
      chk(result == prev, "R7 result kept", int'(result), int'(prev));
      cfg_write(2, 1);
      run_conv(2, 900, 3, 20, 0, shc, bc, ec, fd); // inside conversion
      chk(ec == 0, "R7 no eoc after conversion abort", ec, 0);
      chk(bc == 21, "R7 idle after conversion abort", bc, 21);
      chk(result == prev, "R7 result kept", int'(result), int'(prev));
      chk(int'(result_chan) == 1, "R7 result_chan kept", int'(result_chan), 1);
   endtask

   task automatic t_start_busy;
      int shc, bc, ec, fd;
      cfg_write(4, 1);
      cfg_write(6, 0);
      run_conv(4, 3000, 1, 4, 6, shc, bc, ec, fd);
      chk(shc == 15, "R8 length unchanged", shc, 15);
      chk(bc == 27, "R8 no second conversion", bc, 27);
      chk(int'(result_chan) == 4, "R8 channel unchanged", int'(result_chan), 4);
      run_conv(4, 3001, 1, 20, 6, shc, bc, ec, fd);
      chk(bc == 27 && ec == 1, "R8 start in conversion ignored", bc, 27);
   endtask

   task automatic t_cfg_during;
      int shc, bc, ec, fd;
      cfg_write(7, 2);
      run_conv(7, 555, 2, 5, 0, shc, bc, ec, fd);
      chk(shc == 28, "R9 running conversion keeps length", shc, 28);
      chk(int'(result) == 555, "R9 result", int'(result), 555);
      run_conv(7, 556, 0, -1, 0, shc, bc, ec, fd);
      chk(shc == 3, "R9 next conversion uses new code", shc, 3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_code_sweep();
      t_per_channel();
      t_sar_patterns();
      t_abort();
      t_start_busy();
      t_cfg_during();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule